// File: doc/BRIEF.md
# Lattice coefficient byte encoder

This block packs a polynomial of 256 unsigned coefficients into a dense byte string, as lattice-based key encapsulation schemes do before they transmit or store data. Each coefficient enters in a field `IN_WIDTH` bits wide. Only the low `D` bits of each field are kept, with `D` anywhere from 1 to 12. The kept bits are laid end to end with no padding and then split into `32*D` bytes. When `D` is not a multiple of 8, one byte can hold the tail of one coefficient and the head of the next.

The block is pure combinational logic with no clock and no reset. The output settles from the input in the same cycle. An instantiating design adds registers on either side if its timing needs them. Parameter misuse is caught by assertions in a bound checker.

Top module: `lattice_coef_packer`

## Requirements
- R1: The parameter `D` must lie in 1..12; an assertion fires in simulation if it does not.
- R2: `IN_WIDTH` defaults to 16 and must be at least `D`; an assertion fires if it is smaller.
- R3: The output is exactly `32*D` bytes (256*`D` bits). The final stream bit, bit `D-1` of coefficient 255, lands in bit 7 of the last byte.
- R4: Coefficient i fills stream positions i*`D` up to i*`D`+`D`-1, with no gap between neighbouring coefficients.
- R5: Within a coefficient, its bit 0 (the LSB) is placed first in the stream, at the lowest position.
- R6: Stream position k appears as bit (k mod 8) of output byte (k div 8). Byte j is `bytes_o[8*j+7:8*j]`, so bit 0 of coefficient 0 is bit 0 of byte 0.
- R7: Bits `D` and above of each input field have no effect on the output.
- R8: There is no clock or reset. The output follows any input change without waiting for a clock edge.
- R9: With `D`=1, byte j holds the LSBs of coefficients 8j through 8j+7, with coefficient 8j in bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| coef_i | input | 256*IN_WIDTH | Coefficient i in bits [i*IN_WIDTH +: IN_WIDTH] |
| bytes_o | output | 32*D x 8 | Packed byte array, byte j in element j |

## Verification
A single set bit is walked through coefficients at both ends of the array and through every bit position. This exposes a design that swaps bit order within a coefficient or within a byte, or that pads each coefficient to a byte boundary. Any of those errors moves the lone set bit to a different byte or bit. All-ones fields whose low `D` bits are clear confirm that the upper bits are dropped; a design that kept them would leak ones into neighbouring coefficients. Irregular value patterns at `D`=12 and `D`=1 catch errors in how coefficient fragments split across byte boundaries, and errors in the last byte.

// File: rtl/lattice_coef_packer.sv
module lattice_coef_packer #(
  parameter int D        = 12,
  parameter int IN_WIDTH = 16
) (
  input  logic [256*IN_WIDTH-1:0] coef_i,
  output logic [32*D-1:0][7:0]    bytes_o
);
  localparam int NUM_COEF  = 256;
  localparam int OUT_BYTES = NUM_COEF * D / 8;
  localparam int KEEP      = (D < IN_WIDTH) ? D : IN_WIDTH;

  logic [NUM_COEF*D-1:0] stream;

  for (genvar i = 0; i < NUM_COEF; i++) begin : g_coef
    if (KEEP == D) begin : g_full
      assign stream[i*D +: D] = coef_i[i*IN_WIDTH +: D];
    end else begin : g_short
      assign stream[i*D +: D] = {{(D-KEEP){1'b0}}, coef_i[i*IN_WIDTH +: KEEP]};
    end
  end

  for (genvar j = 0; j < OUT_BYTES; j++) begin : g_byte
    assign bytes_o[j] = stream[j*8 +: 8];
  end
endmodule

module lattice_coef_packer_chk #(
  parameter int D        = 12,
  parameter int IN_WIDTH = 16
) (
  input logic [256*IN_WIDTH-1:0] coef_i,
  input logic [32*D-1:0][7:0]    bytes_o
);
  initial begin
    AST_D_RANGE: assert (D >= 1 && D <= 12) else $error("D out of range"); // R1
    AST_IN_WIDTH: assert (IN_WIDTH >= D) else $error("IN_WIDTH below D"); // R2
  end

  always_comb begin
    AST_FIRST_BIT: assert (bytes_o[0][0] == coef_i[0]); // R6
    AST_LAST_BIT: assert (bytes_o[32*D-1][7] == coef_i[255*IN_WIDTH + D - 1]); // R3
    AST_SECOND_COEF: assert (bytes_o[D/8][D%8] == coef_i[IN_WIDTH]); // R4
  end

  if (D == 1) begin : g_d1
    always_comb begin
      AST_D1_BYTE1: assert (bytes_o[1][0] == coef_i[8*IN_WIDTH] && bytes_o[1][7] == coef_i[15*IN_WIDTH]); // R9
    end
  end
endmodule

bind lattice_coef_packer lattice_coef_packer_chk #(.D(D), .IN_WIDTH(IN_WIDTH)) u_chk (.*);

// File: tb/lattice_coef_packer_bench.sv
module lattice_coef_packer_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [255:0][15:0] coefs;
  logic [383:0][7:0]  out12;
  logic [31:0][7:0]   out1;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  lattice_coef_packer #(.D(12), .IN_WIDTH(16)) u_lattice_coef_packer (
    .coef_i(coefs), .bytes_o(out12));
  lattice_coef_packer #(.D(1), .IN_WIDTH(16)) u_lattice_coef_packer_d1 (
    .coef_i(coefs), .bytes_o(out1));

  function automatic logic [383:0][7:0] model(input logic [255:0][15:0] c, input int d);
    logic [383:0][7:0] r = '0;
    for (int k = 0; k < 256*d; k++) r[k/8][k%8] = c[k/d][k%d];
    return r;
  endfunction

  task automatic check12(input string req, input logic [383:0][7:0] exp);
    checks++;
    if (out12 !== exp) begin
      errors++;
      for (int j = 0; j < 384; j++)
        if (out12[j] !== exp[j]) begin
          $display("FAIL %s: byte %0d actual %h expected %h", req, j, out12[j], exp[j]);
          break;
        end
    end
  endtask

  task automatic check1(input string req, input logic [31:0][7:0] exp);
    checks++;
    if (out1 !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, out1, exp);
    end
  endtask

  task automatic apply(input logic [255:0][15:0] c);
    @(posedge clk);
    #2 coefs = c;
    #1;
  endtask

  task automatic t_zero();
    apply('0);
    check12("R3 zero input", '0);
    check1("R9 zero input", '0);
  endtask

  task automatic t_walk();
    int idx [6] = '{0, 1, 2, 127, 254, 255};
    foreach (idx[n]) begin
      for (int b = 0; b < 12; b++) begin
        logic [255:0][15:0] c = '0;
        logic [383:0][7:0] e = '0;
        int k = idx[n]*12 + b;
        c[idx[n]][b] = 1'b1;
        e[k/8][k%8] = 1'b1;
        apply(c);
        check12($sformatf("R4 R5 R6 walk coef %0d bit %0d", idx[n], b), e);
      end
    end
  endtask

  task automatic t_ones();
    logic [255:0][15:0] c;
    for (int i = 0; i < 256; i++) c[i] = 16'h0FFF;
    apply(c);
    check12("R3 all ones", {384{8'hFF}});
    check1("R9 all ones", {32{8'hFF}});
  endtask

  task automatic t_upper();
    logic [255:0][15:0] c;
    for (int i = 0; i < 256; i++) c[i] = 16'hF000;
    apply(c);
    check12("R7 upper bits D12", '0);
    for (int i = 0; i < 256; i++) c[i] = 16'hFFFE;
    apply(c);
    check1("R7 upper bits D1", '0);
  endtask

  task automatic t_pattern();
    logic [255:0][15:0] c;
    logic [383:0][7:0] m;
    for (int i = 0; i < 256; i++) c[i] = 16'((i*37 + 5) % 4096) | 16'h5000;
    apply(c);
    check12("R4 R6 pattern", model(c, 12));
    m = model(c, 1);
    check1("R9 pattern", m[31:0]);
    for (int i = 0; i < 256; i++) c[i] = 16'((i*i*11 + 3*i) % 4096);
    apply(c);
    check12("R4 R6 pattern2", model(c, 12));
    m = model(c, 1);
    check1("R9 pattern2", m[31:0]);
  endtask

  task automatic t_last();
    logic [255:0][15:0] c = '0;
    logic [383:0][7:0] e = '0;
    c[255] = 16'h0800;
    e[383] = 8'h80;
    apply(c);
    check12("R3 last byte", e);
  endtask

  task automatic t_d1_bytes();
    logic [255:0][15:0] c = '0;
    logic [31:0][7:0] e = '0;
    c[8] = 16'h0001;
    c[15] = 16'h0001;
    c[255] = 16'h0003;
    e[1] = 8'h81;
    e[31] = 8'h80;
    apply(c);
    check1("R9 byte layout", e);
  endtask

  task automatic t_comb();
    logic [383:0][7:0] e = '0;
    @(posedge clk);
    #2 coefs = '0;
    #1 coefs[0] = 16'h0ABC;
    e[0] = 8'hBC;
    e[1] = 8'h0A;
    #1 check12("R8 no clock needed", e);
  endtask

  initial begin
    coefs = '0;
    t_zero();
    t_walk();
    t_ones();
    t_upper();
    t_pattern();
    t_last();
    t_d1_bytes();
    t_comb();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD*100000);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule